// File: doc/BRIEF.md
# Descriptor DMA Suspend Controller

This block sequences one direction of a descriptor-driven DMA engine. Software loads the address of the first descriptor in memory and issues a start. The engine reads the descriptor at its current pointer over a simple request/grant/response read port and tests one ownership bit in the returned word. If the DMA owns the descriptor, the engine runs until the frame logic reports completion. It then steps the pointer to the next descriptor and fetches again. If the DMA does not own the descriptor, the engine parks in a suspended state.

The engine leaves that state only when software issues a poll demand. The poll bit is a pending command that the hardware drops at the moment the re-read of the current descriptor is granted. The transmit variant also suspends when the frame path reports an underflow. The receive variant, chosen by a parameter, ignores that input. Events are logged in sticky write-one-to-clear status bits, and each status bit drives the interrupt line only when its enable bit is set.

Top module: `dscdma_top`

## Requirements
- R1: After reset the engine is STOPPED. A `startCmd` pulse loads the pointer from the list base and moves the engine to FETCH. The state codes are STOPPED=0, FETCH=1, CHECK_OWN=2, RUN=3, SUSPEND=4. A returned word with bit 31 set means the descriptor is DMA-owned, and the engine then enters RUN.
- R2: In RUN, an `underflow` pulse moves the transmit variant (IS_TX=1) to SUSPEND. The receive variant (IS_TX=0) ignores the pulse and stays in RUN.
- R3: The stored list base has its low 2 bits forced to zero, so every read address issued from it is 4-byte aligned.
- R4: SUSPEND persists while no poll demand is pending. A pending poll demand moves the engine to FETCH, which re-reads the same descriptor address.
- R5: `pollWr` sets `pollPend` in any state. `pollPend` clears in the cycle in which a fetch request is granted. A poll issued during RUN therefore stays pending until the next fetch.
- R6: A returned word with bit 31 clear moves the engine to SUSPEND and sets status bit 0.
- R7: Status bits are sticky and are cleared by `statClrWr` with a 1 in that bit position. The bit layout is: bit 0 suspend entered, bit 1 descriptor completed, bit 2 underflow. A set in the same cycle as a clear wins.
- R8: `irq` is high only when some status bit and its matching `intEn` bit are both set. All enables are 0 after reset.
- R9: A `frameDone` pulse in RUN advances the pointer by DESC_BYTES (16) and returns the engine to FETCH. In the transmit variant, an `underflow` in the same cycle takes priority: the engine suspends and the pointer does not move.
- R10: `softRst` returns the engine to STOPPED and clears status, enables and `pollPend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous software reset |
| baseWr | input | 1 | Write strobe for the list base |
| baseData | input | ADDR_W | List base value |
| startCmd | input | 1 | Start pulse (acts only in STOPPED) |
| pollWr | input | 1 | Poll-demand write pulse |
| underflow | input | 1 | Frame underflow pulse (transmit only) |
| frameDone | input | 1 | Descriptor completion pulse |
| rdReq | output | 1 | Descriptor read request |
| rdAddr | output | ADDR_W | Descriptor read address |
| rdGnt | input | 1 | Read request accepted |
| rdValid | input | 1 | Read data valid |
| rdData | input | DATA_W | Read data word |
| statClrWr | input | 1 | Status write-one-to-clear strobe |
| statClrData | input | 3 | Status bits to clear |
| ienWr | input | 1 | Interrupt enable write strobe |
| ienData | input | 3 | Interrupt enable value |
| state | output | 3 | Engine state code |
| pollPend | output | 1 | Poll demand pending |
| curPtr | output | ADDR_W | Current descriptor pointer |
| status | output | 3 | Sticky status bits |
| intEn | output | 3 | Interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences drive the engine through an owned descriptor, an unowned descriptor, a wake-up by poll, and a poll issued while running. These show whether the poll bit drops at the fetch grant and not at the write. A transmit instance and a receive instance run side by side on the same underflow pulse, which separates the two suspend rules. A combined completion-and-underflow cycle checks the priority rule. A seeded random walk over descriptor ownership, with mixed completion, underflow and poll events, compares the pointer and state against a bench-side expectation at every step.

// File: rtl/dscdma_pkg.sv
package dscdma_pkg;
  localparam int ST_W = 3;
  localparam int NSTAT = 3;
  localparam int S_SUSP = 0;
  localparam int S_DONE = 1;
  localparam int S_UNF = 2;

  typedef enum logic [ST_W-1:0] {
    ST_STOP  = 3'd0,
    ST_FETCH = 3'd1,
    ST_CHECK = 3'd2,
    ST_RUN   = 3'd3,
    ST_SUSP  = 3'd4
  } dmaState_t;

  typedef struct packed {
    logic loadPtr;
    logic advPtr;
    logic setSusp;
    logic setDone;
    logic setUnf;
  } dpStrobe_t;
endpackage

// File: rtl/dscdma_ctrl.sv
module dscdma_ctrl
  import dscdma_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       startCmd,
  input  logic       pollWr,
  input  logic       underflow,
  input  logic       frameDone,
  input  logic       rdGnt,
  input  logic       rdValid,
  input  logic       rdOwn,
  output dmaState_t  stQ,
  output logic       pollPend,
  output logic       rdReq,
  output dpStrobe_t  stb
);
  dmaState_t stNxt;
  logic unfEff;

  generate
    if (IS_TX) begin : g_tx
      assign unfEff = underflow;
    end else begin : g_rx
      logic unusedUnf;
      assign unusedUnf = underflow;
      assign unfEff = 1'b0;
    end
  endgenerate

  assign rdReq = (stQ == ST_FETCH);

  always_comb begin
    stNxt = stQ;
    stb = '0;
    case (stQ)
      ST_STOP: if (startCmd) begin
        stNxt = ST_FETCH;
        stb.loadPtr = 1'b1;
      end
      ST_FETCH: if (rdGnt) stNxt = ST_CHECK;
      ST_CHECK: if (rdValid) begin
        if (rdOwn) stNxt = ST_RUN;
        else begin
          stNxt = ST_SUSP;
          stb.setSusp = 1'b1;
        end
      end
      ST_RUN: begin
        if (unfEff) begin
          stNxt = ST_SUSP;
          stb.setSusp = 1'b1;
          stb.setUnf = 1'b1;
        end else if (frameDone) begin
          stNxt = ST_FETCH;
          stb.advPtr = 1'b1;
          stb.setDone = 1'b1;
        end
      end
      ST_SUSP: if (pollPend) stNxt = ST_FETCH;
      default: stNxt = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ <= ST_STOP;
      pollPend <= 1'b0;
    end else if (softRst) begin
      stQ <= ST_STOP;
      pollPend <= 1'b0;
    end else begin
      stQ <= stNxt;
      if (pollWr) pollPend <= 1'b1;
      else if (rdReq && rdGnt) pollPend <= 1'b0;
    end
  end
endmodule

// File: rtl/dscdma_dp.sv
module dscdma_dp
  import dscdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DESC_BYTES = 16,
  parameter int BUS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              baseWr,
  input  logic [ADDR_W-1:0] baseData,
  input  dpStrobe_t         stb,
  input  logic              statClrWr,
  input  logic [NSTAT-1:0]  statClrData,
  input  logic              ienWr,
  input  logic [NSTAT-1:0]  ienData,
  output logic [ADDR_W-1:0] curPtr,
  output logic [NSTAT-1:0]  status,
  output logic [NSTAT-1:0]  intEn,
  output logic              irq
);
  localparam int ALIGN_B = $clog2(BUS_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] baseQ;
  logic [NSTAT-1:0] setVec;
  logic [NSTAT-1:0] clrVec;

  assign setVec[S_SUSP] = stb.setSusp;
  assign setVec[S_DONE] = stb.setDone;
  assign setVec[S_UNF]  = stb.setUnf;
  assign clrVec = statClrWr ? statClrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      curPtr <= '0;
      intEn <= '0;
    end else if (softRst) begin
      intEn <= '0;
    end else begin
      if (baseWr) baseQ <= {baseData[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
      if (stb.loadPtr) curPtr <= baseQ;
      else if (stb.advPtr) curPtr <= curPtr + STEP;
      if (ienWr) intEn <= ienData;
    end
  end

  generate
    for (genvar i = 0; i < NSTAT; i++) begin : g_stat
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) status[i] <= 1'b0;
        else if (softRst) status[i] <= 1'b0;
        else status[i] <= setVec[i] | (status[i] & ~clrVec[i]);
      end
    end
  endgenerate

  assign irq = |(status & intEn);
endmodule

// File: rtl/dscdma_top.sv
module dscdma_top
  import dscdma_pkg::*;
#(
  parameter bit IS_TX = 1'b1,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OWN_BIT = 31,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              baseWr,
  input  logic [ADDR_W-1:0] baseData,
  input  logic              startCmd,
  input  logic              pollWr,
  input  logic              underflow,
  input  logic              frameDone,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdGnt,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  input  logic              statClrWr,
  input  logic [2:0]        statClrData,
  input  logic              ienWr,
  input  logic [2:0]        ienData,
  output logic [2:0]        state,
  output logic              pollPend,
  output logic [ADDR_W-1:0] curPtr,
  output logic [2:0]        status,
  output logic [2:0]        intEn,
  output logic              irq
);
  dmaState_t stQ;
  dpStrobe_t stb;
  logic unusedData;

  assign unusedData = ^rdData;

  dscdma_ctrl #(.IS_TX(IS_TX)) ctrl_i (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .startCmd(startCmd), .pollWr(pollWr),
    .underflow(underflow), .frameDone(frameDone),
    .rdGnt(rdGnt), .rdValid(rdValid), .rdOwn(rdData[OWN_BIT]),
    .stQ(stQ), .pollPend(pollPend), .rdReq(rdReq), .stb(stb)
  );

  dscdma_dp #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .baseWr(baseWr), .baseData(baseData), .stb(stb),
    .statClrWr(statClrWr), .statClrData(statClrData),
    .ienWr(ienWr), .ienData(ienData),
    .curPtr(curPtr), .status(status), .intEn(intEn), .irq(irq)
  );

  assign state = stQ;
  assign rdAddr = curPtr;
endmodule

// File: rtl/dscdma_chk.sv
module dscdma_chk #(
  parameter bit IS_TX = 1'b1,
  parameter int ADDR_W = 32,
  parameter int DESC_BYTES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              softRst,
  input logic              pollWr,
  input logic              underflow,
  input logic              frameDone,
  input logic              rdReq,
  input logic              rdGnt,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [2:0]        state,
  input logic              pollPend,
  input logic [ADDR_W-1:0] curPtr,
  input logic [2:0]        status,
  input logic [2:0]        intEn
);
  logic inSusp, inRun;
  assign inSusp = (state == 3'd4);
  assign inRun = (state == 3'd3);

  a_r3_addr_aligned: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> rdAddr[1:0] == 2'b00);

  a_r5_poll_selfclear: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdGnt && !pollWr && !softRst) |=> !pollPend);

  a_r4_wake_on_poll: assert property (@(posedge clk) disable iff (!rstN)
    (inSusp && pollPend && !softRst) |=> state == 3'd1);

  a_r4_hold_suspend: assert property (@(posedge clk) disable iff (!rstN)
    (inSusp && !pollPend && !softRst) |=> inSusp);

  a_r6_susp_status: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSusp) |-> status[0]);

  a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && frameDone && !(IS_TX && underflow) && !softRst)
    |=> curPtr == $past(curPtr) + ADDR_W'(DESC_BYTES));

  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (state == 3'd0 && status == 3'b000 && intEn == 3'b000 && !pollPend));

  generate
    if (!IS_TX) begin : g_rx
      a_r2_rx_no_unf: assert property (@(posedge clk) disable iff (!rstN)
        (inRun && underflow && !frameDone && !softRst) |=> inRun);
    end
  endgenerate
endmodule

bind dscdma_top dscdma_chk #(.IS_TX(IS_TX), .ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .softRst(softRst), .pollWr(pollWr),
  .underflow(underflow), .frameDone(frameDone), .rdReq(rdReq),
  .rdGnt(rdGnt), .rdAddr(rdAddr), .state(state), .pollPend(pollPend),
  .curPtr(curPtr), .status(status), .intEn(intEn)
);

// File: tb/dscdma_top_tb_top.sv
module dscdma_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0, baseWr = 1'b0, startCmd = 1'b0, pollWr = 1'b0;
  logic underflow = 1'b0, frameDone = 1'b0, statClrWr = 1'b0, ienWr = 1'b0;
  logic [31:0] baseData = '0;
  logic [2:0] statClrData = '0, ienData = '0;

  logic txReq, txPoll, txIrq, rxReq, rxPoll, rxIrq;
  logic [31:0] txAddr, txPtr, rxAddr, rxPtr;
  logic [2:0] txState, txStat, txIen, rxState, rxStat, rxIen;
  logic txVal = 1'b0, rxVal = 1'b0;
  logic [31:0] txData = '0, rxData = '0, txLast = '0;
  logic ownMap [0:63];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dscdma_top #(.IS_TX(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .baseWr(baseWr), .baseData(baseData),
    .startCmd(startCmd), .pollWr(pollWr), .underflow(underflow), .frameDone(frameDone),
    .rdReq(txReq), .rdAddr(txAddr), .rdGnt(txReq), .rdValid(txVal), .rdData(txData),
    .statClrWr(statClrWr), .statClrData(statClrData), .ienWr(ienWr), .ienData(ienData),
    .state(txState), .pollPend(txPoll), .curPtr(txPtr), .status(txStat),
    .intEn(txIen), .irq(txIrq));

  dscdma_top #(.IS_TX(1'b0)) dutRx_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .baseWr(baseWr), .baseData(baseData),
    .startCmd(startCmd), .pollWr(pollWr), .underflow(underflow), .frameDone(frameDone),
    .rdReq(rxReq), .rdAddr(rxAddr), .rdGnt(rxReq), .rdValid(rxVal), .rdData(rxData),
    .statClrWr(statClrWr), .statClrData(statClrData), .ienWr(ienWr), .ienData(ienData),
    .state(rxState), .pollPend(rxPoll), .curPtr(rxPtr), .status(rxStat),
    .intEn(rxIen), .irq(rxIrq));

  always_ff @(posedge clk) begin
    txVal <= txReq;
    txData <= {ownMap[txAddr[9:4]], 31'b0};
    rxVal <= rxReq;
    rxData <= {ownMap[rxAddr[9:4]], 31'b0};
    if (txReq) txLast <= txAddr;
  end

  function automatic logic [31:0] alignBase(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; tick(1); sig = 1'b0;
  endtask

  task automatic clearAll();
    statClrData = 3'b111; pulse(statClrWr); statClrData = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] expPtr;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) ownMap[i] = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 / R8 / R10 reset state
    chk("R1 reset state", {29'b0, txState}, 32'd0);
    chk("R8 reset enables", {29'b0, txIen}, 32'd0);
    chk("R8 reset irq", {31'b0, txIrq}, 32'd0);
    chk("R5 reset poll", {31'b0, txPoll}, 32'd0);

    ownMap[0] = 1'b1; ownMap[1] = 1'b0; ownMap[2] = 1'b1;
    baseData = 32'h0000_1003; pulse(baseWr);
    pulse(startCmd);
    tick(4);
    chk("R3 aligned fetch address", txLast, alignBase(32'h1003));
    chk("R1 owned descriptor runs", {29'b0, txState}, 32'd3);

    // R9 completion advances, R6 unowned suspends
    pulse(frameDone);
    tick(4);
    chk("R9 pointer step", txPtr, 32'h1010);
    chk("R6 unowned suspends", {29'b0, txState}, 32'd4);
    chk("R6 suspend status", {31'b0, txStat[0]}, 32'd1);
    chk("R7 done status", {31'b0, txStat[1]}, 32'd1);
    chk("R8 irq masked", {31'b0, txIrq}, 32'd0);
    ienData = 3'b001; pulse(ienWr);
    chk("R8 irq enabled", {31'b0, txIrq}, 32'd1);
    statClrData = 3'b001; pulse(statClrWr); statClrData = '0;
    chk("R7 w1c clears bit0", {29'b0, txStat}, 32'b010);
    chk("R8 irq after clear", {31'b0, txIrq}, 32'd0);

    // R4 hold without poll, then wake
    tick(6);
    chk("R4 holds suspend", {29'b0, txState}, 32'd4);
    ownMap[1] = 1'b1;
    pulse(pollWr);
    chk("R5 poll pending", {31'b0, txPoll}, 32'd1);
    chk("R4 still suspended at write", {29'b0, txState}, 32'd4);
    tick(4);
    chk("R5 poll self-cleared", {31'b0, txPoll}, 32'd0);
    chk("R4 re-fetch same address", txLast, 32'h1010);
    chk("R4 woken to run", {29'b0, txState}, 32'd3);

    // R5 poll during RUN stays pending until next fetch
    pulse(pollWr);
    tick(2);
    chk("R5 poll pending in run", {31'b0, txPoll}, 32'd1);
    pulse(frameDone);
    tick(3);
    chk("R5 poll cleared by fetch", {31'b0, txPoll}, 32'd0);
    chk("R1 run at next", {29'b0, txState}, 32'd3);

    // R2 underflow: tx suspends, rx ignores
    clearAll();
    pulse(underflow);
    tick(1);
    chk("R2 tx suspends on underflow", {29'b0, txState}, 32'd4);
    chk("R7 underflow status", {29'b0, txStat}, 32'b101);
    chk("R2 rx ignores underflow", {29'b0, rxState}, 32'd3);

    // R9 simultaneous done and underflow
    pulse(pollWr);
    tick(4);
    chk("R4 wake for R9 case", {29'b0, txState}, 32'd3);
    underflow = 1'b1; frameDone = 1'b1; tick(1); underflow = 1'b0; frameDone = 1'b0;
    tick(1);
    chk("R9 underflow wins", {29'b0, txState}, 32'd4);
    chk("R9 pointer unchanged", txPtr, 32'h1020);

    // R10 soft reset
    ienData = 3'b111; pulse(ienWr);
    pulse(softRst);
    chk("R10 state stopped", {29'b0, txState}, 32'd0);
    chk("R10 status cleared", {29'b0, txStat}, 32'd0);
    chk("R10 enables cleared", {29'b0, txIen}, 32'd0);

    // random walk
    for (int i = 0; i < 64; i++) ownMap[i] = 1'($urandom % 2);
    baseData = 32'h0000_2000 | ($urandom % 4); pulse(baseWr);
    expPtr = 32'h2000;
    pulse(startCmd);
    for (int it = 0; it < 60; it++) begin
      tick(6);
      chk("R9 random pointer", txPtr, expPtr);
      if (txState == 3'd3) begin
        if ($urandom % 4 == 0) begin
          pulse(underflow);
          tick(1);
          chk("R2 random underflow", {29'b0, txState}, 32'd4);
        end else begin
          pulse(frameDone);
          expPtr = expPtr + 32'd16;
        end
      end else begin
        logic o;
        chk("R6 random suspend", {29'b0, txState}, 32'd4);
        o = 1'($urandom % 2);
        ownMap[expPtr[9:4]] = o;
        pulse(pollWr);
        tick(5);
        chk("R4 random wake", {29'b0, txState}, o ? 32'd3 : 32'd4);
        chk("R5 random poll clear", {31'b0, txPoll}, 32'd0);
      end
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule